// File: doc/BRIEF.md
# UDP Stream Port Classifier

This block sits right after an Ethernet receive path. It takes in whole frames as a byte stream and sends each frame to one of three outputs. The first output is a record path for sample streams. The second is a path for address-resolution frames. The third is a control path for every other frame. No frame is dropped unless it is a sample stream. For those frames the Ethernet, IPv4 and UDP headers are used up inside the block, and only the payload goes on.

The block holds the first 42 bytes of each frame before it decides the route. This covers a 14-byte Ethernet header, a 20-byte IPv4 header and an 8-byte UDP header. A frame that ends sooner is decided on the bytes it has. When the frame is a sample stream, the payload is split into 48-bit records. The 16-bit stream index goes out on its own side field. The I and Q samples go out together as one 32-bit word. When the frame goes to the address-resolution or control output, the held bytes are sent first and the rest of the frame follows without change.

Top module: `udp_stream_sorter`

## Requirements
- R1: After reset `inReady` is 1 and `dsValid`, `arpValid` and `ctlValid` are all 0.
- R2: A frame is a sample stream only when all of these hold: bytes 12..13 are 0x0800, the low nibble of byte 14 is 5, byte 23 is 17, and the big-endian port in bytes 36..37 is between 30000 and 30255, both limits included. None of its bytes appear on the ARP or control outputs.
- R3: The payload of a sample stream starts at byte 42. Each six payload bytes p0..p5 produce one record. `dsIndex` is {p0,p1}. `dsIq[31:16]` is the I sample {p2,p3} and `dsIq[15:0]` is the Q sample {p4,p5}. Records come out in arrival order.
- R4: When a sample-stream payload ends with fewer than six bytes left, those bytes produce no record, and the next frame is handled normally.
- R5: A frame of at least 14 bytes whose bytes 12..13 are 0x0806 comes out byte for byte on `arpData`. `arpLast` is 1 on its final byte only.
- R6: Every other frame comes out byte for byte on `ctlData`, with `ctlLast` on its final byte. This includes wrong ports (29999, 30256), other IP protocols, an IPv4 header length other than 5, and frames shorter than 42 bytes.
- R7: No byte of a frame appears on the ARP or control outputs while its first 42 bytes (or the whole frame, if it is shorter) are still coming in. `arpValid` and `ctlValid` are never 1 in the same cycle.
- R8: If an output's valid is 1 while its ready is 0, the valid stays 1 and the data stays the same in the next cycle. No byte or record is lost or repeated under any ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 8 | Incoming frame byte |
| inValid | input | 1 | Incoming byte is valid |
| inLast | input | 1 | Final byte of the frame |
| inReady | output | 1 | Block accepts the byte |
| dsIndex | output | 16 | Stream index of the record |
| dsIq | output | 32 | I sample (upper half) and Q sample (lower half) |
| dsValid | output | 1 | Record is valid |
| dsReady | input | 1 | Record consumer ready |
| arpData | output | 8 | Address-resolution frame byte |
| arpValid | output | 1 | ARP byte valid |
| arpLast | output | 1 | Final ARP byte |
| arpReady | input | 1 | ARP consumer ready |
| ctlData | output | 8 | Control frame byte |
| ctlValid | output | 1 | Control byte valid |
| ctlLast | output | 1 | Final control byte |
| ctlReady | input | 1 | Control consumer ready |

## Verification
The assertions check four things on every cycle. A stalled record or byte is held in place while its ready is low. No byte goes out while the header is still being collected. The header counters stay inside the buffer. A final ARP byte puts the block back into header collection. Routing, record assembly and order, dropping of partial records, and the exact port limits can only be shown by the bench's frames. The bench compares them against a behavioural model, with every ready held high and with every ready toggled at random.

// File: rtl/udp_stream_sorter_pkg.sv
package udp_stream_sorter_pkg;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 16;
  localparam int SMP_W     = 16;
  localparam int REC_W     = IDX_W + 2 * SMP_W;
  localparam int REC_BYTES = REC_W / BYTE_W;
  localparam int HDR_BYTES = 42;
  localparam int ETH_BYTES = 14;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);
  localparam int REC_CNT_W = $clog2(REC_BYTES);

  typedef enum logic [1:0] {PATH_CTL, PATH_ARP, PATH_DS} pathT;

  typedef enum logic [2:0] {ST_HDR, ST_DECIDE, ST_REPLAY, ST_PASS, ST_DS} stateT;

  typedef struct packed {
    logic             capture;
    logic [CNT_W-1:0] capIdx;
    logic [CNT_W-1:0] hdrLen;
    logic [CNT_W-1:0] rdIdx;
    logic             useBuf;
    logic             asmShift;
    logic             asmEmit;
  } dpCtlT;
endpackage

// File: rtl/udp_stream_sorter_dp.sv
module udp_stream_sorter_dp
  import udp_stream_sorter_pkg::*;
#(
  parameter logic [15:0] PORT_LO = 16'd30000,
  parameter logic [15:0] PORT_HI = 16'd30255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  dpCtlT             ctl,
  input  logic              dsReady,
  output logic              isArp,
  output logic              isDs,
  output logic              dsBusy,
  output logic [BYTE_W-1:0] byteOut,
  output logic [IDX_W-1:0]  dsIndex,
  output logic [2*SMP_W-1:0] dsIq,
  output logic              dsValid
);
  logic [BYTE_W-1:0] hdrBuf [HDR_BYTES];
  logic [REC_W-BYTE_W-1:0] asmReg;
  logic [15:0] etherType;
  logic [15:0] dstPort;

  always_ff @(posedge clk) begin
    if (ctl.capture) hdrBuf[ctl.capIdx] <= inData;
  end

  always_comb begin
    etherType = {hdrBuf[12], hdrBuf[13]};
    dstPort   = {hdrBuf[36], hdrBuf[37]};
    isArp = (ctl.hdrLen >= CNT_W'(ETH_BYTES)) && (etherType == 16'h0806);
    isDs  = (ctl.hdrLen == CNT_W'(HDR_BYTES)) && (etherType == 16'h0800)
            && (hdrBuf[14][3:0] == 4'd5) && (hdrBuf[23] == 8'd17)
            && (dstPort >= PORT_LO) && (dstPort <= PORT_HI);
    byteOut = ctl.useBuf ? hdrBuf[ctl.rdIdx] : inData;
    dsBusy  = dsValid && !dsReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg  <= '0;
      dsIndex <= '0;
      dsIq    <= '0;
      dsValid <= 1'b0;
    end else begin
      if (ctl.asmShift) asmReg <= {asmReg[REC_W-2*BYTE_W-1:0], inData};
      if (ctl.asmEmit) begin
        {dsIndex, dsIq} <= {asmReg, inData};
        dsValid <= 1'b1;
      end else if (dsReady) begin
        dsValid <= 1'b0;
      end
    end
  end

  AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dsValid && !dsReady) |=> (dsValid && $stable(dsIndex) && $stable(dsIq))); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.asmEmit |-> !(dsValid && !dsReady)); // R8
endmodule

// File: rtl/udp_stream_sorter_ctl.sv
module udp_stream_sorter_ctl
  import udp_stream_sorter_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inLast,
  input  logic  isArp,
  input  logic  isDs,
  input  logic  dsBusy,
  input  logic  arpReady,
  input  logic  ctlReady,
  output logic  inReady,
  output logic  arpValid,
  output logic  arpLast,
  output logic  ctlValid,
  output logic  ctlLast,
  output dpCtlT dp
);
  stateT st;
  pathT  path;
  logic [CNT_W-1:0]     hdrCnt;
  logic [CNT_W-1:0]     hdrLen;
  logic [CNT_W-1:0]     rdIdx;
  logic [REC_CNT_W-1:0] asmCnt;
  logic sawLast;
  logic selReady, byteValid, byteLast, accept, lastRead, recDone;

  always_comb begin
    selReady  = (path == PATH_ARP) ? arpReady : ctlReady;
    lastRead  = (rdIdx == hdrLen - 1'b1);
    recDone   = (asmCnt == REC_CNT_W'(REC_BYTES - 1));
    byteValid = 1'b0;
    byteLast  = 1'b0;
    inReady   = 1'b0;
    case (st)
      ST_HDR:    inReady = 1'b1;
      ST_REPLAY: begin
        byteValid = 1'b1;
        byteLast  = sawLast && lastRead;
      end
      ST_PASS: begin
        byteValid = inValid;
        byteLast  = inLast;
        inReady   = selReady;
      end
      ST_DS:     inReady = !(recDone && dsBusy);
      default:   inReady = 1'b0;
    endcase
    accept   = inValid && inReady;
    arpValid = byteValid && (path == PATH_ARP);
    ctlValid = byteValid && (path == PATH_CTL);
    arpLast  = byteLast && (path == PATH_ARP);
    ctlLast  = byteLast && (path == PATH_CTL);

    dp.capture  = (st == ST_HDR) && accept;
    dp.capIdx   = hdrCnt;
    dp.hdrLen   = hdrLen;
    dp.rdIdx    = rdIdx;
    dp.useBuf   = (st == ST_REPLAY);
    dp.asmShift = (st == ST_DS) && accept;
    dp.asmEmit  = (st == ST_DS) && accept && recDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_HDR;
      path    <= PATH_CTL;
      hdrCnt  <= '0;
      hdrLen  <= '0;
      rdIdx   <= '0;
      asmCnt  <= '0;
      sawLast <= 1'b0;
    end else begin
      case (st)
        ST_HDR: if (accept) begin
          if (inLast || hdrCnt == CNT_W'(HDR_BYTES - 1)) begin
            hdrLen  <= hdrCnt + 1'b1;
            sawLast <= inLast;
            hdrCnt  <= '0;
            st      <= ST_DECIDE;
          end else begin
            hdrCnt <= hdrCnt + 1'b1;
          end
        end
        ST_DECIDE: begin
          rdIdx  <= '0;
          asmCnt <= '0;
          if (isDs) begin
            path <= PATH_DS;
            st   <= sawLast ? ST_HDR : ST_DS;
          end else begin
            path <= isArp ? PATH_ARP : PATH_CTL;
            st   <= ST_REPLAY;
          end
        end
        ST_REPLAY: if (selReady) begin
          if (lastRead) st <= sawLast ? ST_HDR : ST_PASS;
          else rdIdx <= rdIdx + 1'b1;
        end
        ST_PASS: if (accept && inLast) st <= ST_HDR;
        ST_DS: if (accept) begin
          asmCnt <= (recDone || inLast) ? '0 : asmCnt + 1'b1;
          if (inLast) st <= ST_HDR;
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HDR || st == ST_DECIDE) |-> (!arpValid && !ctlValid)); // R7
  AST_HDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (hdrCnt < CNT_W'(HDR_BYTES)) && (hdrLen <= CNT_W'(HDR_BYTES))); // R2
  AST_REPLAY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REPLAY) |-> (rdIdx < hdrLen)); // R5
  AST_ARP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REPLAY && arpValid && !arpReady) |=> (arpValid && $stable(rdIdx))); // R8
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REPLAY && ctlValid && !ctlReady) |=> (ctlValid && $stable(rdIdx))); // R8
  AST_ARP_END: assert property (@(posedge clk) disable iff (!rstN)
    (arpValid && arpReady && arpLast) |=> (st == ST_HDR)); // R5
endmodule

// File: rtl/udp_stream_sorter.sv
module udp_stream_sorter
  import udp_stream_sorter_pkg::*;
#(
  parameter logic [15:0] PORT_LO = 16'd30000,
  parameter logic [15:0] PORT_HI = 16'd30255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inData,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic [15:0] dsIndex,
  output logic [31:0] dsIq,
  output logic        dsValid,
  input  logic        dsReady,
  output logic [7:0]  arpData,
  output logic        arpValid,
  output logic        arpLast,
  input  logic        arpReady,
  output logic [7:0]  ctlData,
  output logic        ctlValid,
  output logic        ctlLast,
  input  logic        ctlReady
);
  dpCtlT dpCtl;
  logic isArp, isDs, dsBusy;
  logic [BYTE_W-1:0] byteOut;

  udp_stream_sorter_ctl i_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .isArp(isArp), .isDs(isDs), .dsBusy(dsBusy),
    .arpReady(arpReady), .ctlReady(ctlReady), .inReady(inReady),
    .arpValid(arpValid), .arpLast(arpLast), .ctlValid(ctlValid),
    .ctlLast(ctlLast), .dp(dpCtl)
  );

  udp_stream_sorter_dp #(.PORT_LO(PORT_LO), .PORT_HI(PORT_HI)) i_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .ctl(dpCtl), .dsReady(dsReady),
    .isArp(isArp), .isDs(isDs), .dsBusy(dsBusy), .byteOut(byteOut),
    .dsIndex(dsIndex), .dsIq(dsIq), .dsValid(dsValid)
  );

  assign arpData = byteOut;
  assign ctlData = byteOut;
endmodule

// File: tb/test_udp_stream_sorter.sv
`timescale 1ns/1ps
module test_udp_stream_sorter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0, inReady;
  logic [15:0] dsIndex;
  logic [31:0] dsIq;
  logic dsValid, dsReady = 1'b1;
  logic [7:0] arpData, ctlData;
  logic arpValid, arpLast, arpReady = 1'b1;
  logic ctlValid, ctlLast, ctlReady = 1'b1;

  int total = 0, bad = 0;
  bit running = 1'b0, randReady = 1'b0, finished = 1'b0;
  string curReq = "R2";
  byte unsigned frm[$];
  logic [8:0]  expArp[$], expCtl[$];
  logic [47:0] expDs[$];

  always #10 clk = ~clk;

  udp_stream_sorter i_udp_stream_sorter (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .dsIndex(dsIndex), .dsIq(dsIq), .dsValid(dsValid),
    .dsReady(dsReady), .arpData(arpData), .arpValid(arpValid), .arpLast(arpLast),
    .arpReady(arpReady), .ctlData(ctlData), .ctlValid(ctlValid), .ctlLast(ctlLast),
    .ctlReady(ctlReady)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ready pattern: always high or random, changed just after the rising edge
  initial forever begin
    @(posedge clk); #1;
    dsReady  = randReady ? 1'($urandom % 2) : 1'b1;
    arpReady = randReady ? 1'($urandom % 2) : 1'b1;
    ctlReady = randReady ? 1'($urandom % 2) : 1'b1;
  end

  // Monitor at the falling edge: a handshake seen here completes at the next rising edge
  always @(negedge clk) if (running) begin
    logic [47:0] eDs;
    logic [8:0] eB;
    if (arpValid || ctlValid) check(!(arpValid && ctlValid), "R7 exclusive", {arpValid, ctlValid}, 0);
    if (dsValid && dsReady) begin
      eDs = (expDs.size() > 0) ? expDs.pop_front() : 48'hx;
      check({dsIndex, dsIq} === eDs, {curReq, " R3 record"}, {dsIndex, dsIq}, eDs);
    end
    if (arpValid && arpReady) begin
      eB = (expArp.size() > 0) ? expArp.pop_front() : 9'hx;
      check({arpLast, arpData} === eB, {curReq, " R5 arp byte"}, {arpLast, arpData}, eB);
    end
    if (ctlValid && ctlReady) begin
      eB = (expCtl.size() > 0) ? expCtl.pop_front() : 9'hx;
      check({ctlLast, ctlData} === eB, {curReq, " R6 ctl byte"}, {ctlLast, ctlData}, eB);
    end
  end

  task automatic fillHeader(int etype, int seed);
    frm.delete();
    for (int i = 0; i < 42; i++) frm.push_back(8'((i * 29 + seed * 11 + 3) & 8'hff));
    frm[12] = 8'(etype >> 8);
    frm[13] = 8'(etype & 8'hff);
  endtask

  task automatic buildUdp(int port, int ihl, int proto, int nPay, int seed);
    fillHeader(16'h0800, seed);
    frm[14] = 8'(8'h40 | ihl);
    frm[23] = 8'(proto);
    frm[36] = 8'(port >> 8);
    frm[37] = 8'(port & 8'hff);
    for (int i = 0; i < nPay; i++) frm.push_back(8'((seed * 7 + i * 13 + 1) & 8'hff));
  endtask

  task automatic buildOther(int etype, int n, int seed);
    fillHeader(etype, seed);
    while (frm.size() > n) void'(frm.pop_back());
    while (frm.size() < n) frm.push_back(8'((frm.size() * 5 + seed) & 8'hff));
  endtask

  // Reference model taken from the requirements
  task automatic predict();
    int n = frm.size();
    int port;
    bit isDs, isArp;
    port  = (n >= 38) ? {frm[36], frm[37]} : 0;
    isDs  = (n >= 42) && frm[12] == 8'h08 && frm[13] == 8'h00 && frm[14][3:0] == 4'd5
            && frm[23] == 8'd17 && port >= 30000 && port <= 30255;
    isArp = (n >= 14) && frm[12] == 8'h08 && frm[13] == 8'h06;
    if (isDs) begin
      for (int k = 42; k + 6 <= n; k += 6)
        expDs.push_back({frm[k], frm[k+1], frm[k+2], frm[k+3], frm[k+4], frm[k+5]});
    end else begin
      for (int i = 0; i < n; i++) begin
        if (isArp) expArp.push_back({i == n - 1, frm[i]});
        else       expCtl.push_back({i == n - 1, frm[i]});
      end
    end
  endtask

  task automatic sendFrame();
    bit acc;
    predict();
    for (int i = 0; i < frm.size(); i++) begin
      inData = frm[i]; inValid = 1'b1; inLast = (i == frm.size() - 1);
      do begin
        @(negedge clk); acc = inReady;
        @(posedge clk); #1;
      end while (!acc);
    end
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic runAll();
    curReq = "R2"; buildUdp(30000, 5, 17, 18, 1); sendFrame();      // low limit, 3 records
    curReq = "R4"; buildUdp(30255, 5, 17, 16, 2); sendFrame();      // high limit, 2 records + 4 dropped
    curReq = "R2"; buildUdp(30100, 5, 17, 0, 3);  sendFrame();      // no payload
    curReq = "R6"; buildUdp(29999, 5, 17, 12, 4); sendFrame();      // below window
    buildUdp(30256, 5, 17, 12, 5); sendFrame();                     // above window
    buildUdp(30010, 5, 6, 6, 6);   sendFrame();                     // not UDP
    buildUdp(30010, 6, 17, 6, 7);  sendFrame();                     // header length 6
    buildOther(16'h0800, 10, 8);   sendFrame();                     // short frame
    buildOther(16'h86dd, 50, 9);   sendFrame();                     // other type
    curReq = "R5"; buildOther(16'h0806, 42, 10); sendFrame();       // exact header length
    buildOther(16'h0806, 60, 11);  sendFrame();                     // with pass-through tail
    buildOther(16'h0806, 20, 12);  sendFrame();                     // short ARP
    curReq = "R3"; buildUdp(30200, 5, 17, 36, 13); sendFrame();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(inReady === 1'b1 && !dsValid && !arpValid && !ctlValid, "R1 reset",
          {inReady, dsValid, arpValid, ctlValid}, 4'b1000);
    @(posedge clk); #1;
    running = 1'b1;
    runAll();
    repeat (100) @(posedge clk);
    #1 randReady = 1'b1;                   // R8 random back-pressure pass
    runAll();
    repeat (300) @(posedge clk);
    #1 randReady = 1'b0;
    repeat (20) @(posedge clk);
    running = 1'b0;
    check(expDs.size() == 0,  "R3 records left", expDs.size(), 0);
    check(expArp.size() == 0, "R5 arp bytes left", expArp.size(), 0);
    check(expCtl.size() == 0, "R6 ctl bytes left", expCtl.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule